// File: doc/BRIEF.md
# Serial Configuration Register Receiver

This block takes 16-bit configuration words from one serial line that is clocked by the word clock, and writes them into a bank of control registers. The registers drive the settings of the rest of the analog front end: receive gain and input selection, transmit attenuation, general-purpose outputs, loopback and filter modes, filter tuning, the oscillator-tuning DAC value, the oversampling mode and the per-module power enables. A frame is written only after the line has returned to idle-high for a full guard interval. A frame that the next start bit cuts short is dropped.

A three-state machine reads the line on every falling edge of the word clock. `ST_IDLE` waits for a low start bit and moves to `ST_DATA`. `ST_DATA` shifts in the 15 remaining bits and moves to `ST_STOP` after the last one. `ST_STOP` counts consecutive high bits. When the 16th arrives it commits the frame and returns to `ST_IDLE`. A low bit in `ST_STOP` drops the pending frame and goes straight to `ST_DATA`, because that low bit is the start of the next frame. The power-down pin passes through a two-stage synchronizer. While it is asserted, the transmit gain output is forced to its loudest code and the stored registers are kept.

Top module: `cfg_serial_ctl`

## Requirements
- R1: `ser_in` is sampled on the falling edge of `word_clk`. A frame is 16 bits sent most significant bit first. Bit 15 is a start bit equal to 0, bits 14..3 form the 12-bit payload p[11:0], and bits 2..0 are the register ID.
- R2: A frame is committed on the falling edge that samples the 16th consecutive high bit after its last data bit. Before that edge, no register output changes.
- R3: If a low bit arrives before 16 stop bits have been seen, the pending frame is discarded and that low bit is taken as the start bit of a new frame.
- R4: ID 1 writes the receive register: `rx_gain` = p[4:0] (0..31 dB in 1 dB steps), `rx_in_sel` = p[6:5], `ext_gain_ctl` = p[8:7], `filt_force` = p[10:9].
- R5: ID 2 writes the transmit register: the stored code X = p[3:0], meaning (X-15) dB, and `gpo` = p[11:9].
- R6: ID 3 writes the mode register: `loop_mode` = p[1:0], `vco_dac_en` = p[2], `hc2_en` = p[3], `osr2_mode` = p[4] (0 means oversampling by 4, 1 means by 2), `vco_filt` = p[5].
- R7: ID 4 writes the tuning register: `hc_tune` = p[2:0] and `sc_tune` = p[5:3`]`, each a two's-complement value from -4 (100) to +3 (011).
- R8: ID 5 writes `vco_dac_val` = p[7:0]. ID 6 writes `pwr_en` = p[7:0], where a 1 means the module is active.
- R9: Frames with ID 0 or ID 7 leave every output unchanged.
- R10: A low `rst_n` sets the outputs at once, without a clock edge, to: rx_gain 0, rx_in_sel 11, ext_gain_ctl 00, filt_force 00, tx_gain 0, gpo 0, loop_mode 00, vco_dac_en 0, hc2_en 0, osr2_mode 0, vco_filt 0, both tunes 0, vco_dac_val 0, pwr_en 8'hFF, pd_status 0.
- R11: `pd_status` follows `pdn_pin` on the second falling edge of `word_clk` after the pin changes, which is within 3 cycles.
- R12: While `pd_status` is 1, `tx_gain` reads 15 (0 dB). Frames are still committed, and all stored contents, including the transmit code, show again once `pd_status` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_clk | input | 1 | Word clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Serial configuration line, idle high |
| pdn_pin | input | 1 | Power-down request, asynchronous to the block |
| rx_gain | output | 5 | Receive gain code in dB |
| rx_in_sel | output | 2 | Receive input selection |
| ext_gain_ctl | output | 2 | External gain-control outputs |
| filt_force | output | 2 | Receive filter forcing mode |
| tx_gain | output | 4 | Effective transmit gain code, (code-15) dB |
| gpo | output | 3 | General-purpose outputs |
| loop_mode | output | 2 | Loopback mode select |
| vco_dac_en | output | 1 | Oscillator-tuning DAC enable |
| hc2_en | output | 1 | Second receive filter enable |
| osr2_mode | output | 1 | 1 selects oversampling by 2 |
| vco_filt | output | 1 | Filtered oscillator control path select |
| hc_tune | output | 3 | Receive filter tuning, two's complement |
| sc_tune | output | 3 | Transmit filter tuning, two's complement |
| vco_dac_val | output | 8 | Oscillator-tuning DAC value |
| pwr_en | output | 8 | Per-module active enables |
| pd_status | output | 1 | Synchronized power-down status |

## Verification
Most internal faults show up at the ports at the next commit. A shift-register slip or a wrong bit counter puts payload bits in the wrong fields, or leaves a frame uncommitted, on the edge where the 16th stop bit is sampled. A stop counter that miscounts commits one edge early or late, or commits a frame that was cut short. A wrong synchronizer depth shows as `pd_status` and `tx_gain` changing on the wrong edge after the pin moves.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam int FRAME_W = 16;
    localparam int ID_W    = 3;
    localparam int PAY_W   = FRAME_W - 1 - ID_W;
    localparam int RXG_W   = 5;
    localparam int TXG_W   = 4;
    localparam int TUNE_W  = 3;
    localparam int DAC_W   = 8;
    localparam int PWR_W   = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_STOP
    } rx_state_t;

    typedef enum logic [ID_W-1:0] {
        ID_NONE  = 3'd0,
        ID_RX    = 3'd1,
        ID_TX    = 3'd2,
        ID_MODE  = 3'd3,
        ID_TUNE  = 3'd4,
        ID_VDAC  = 3'd5,
        ID_PWR   = 3'd6,
        ID_SPARE = 3'd7
    } reg_id_t;

    typedef struct packed {
        logic [RXG_W-1:0]  rx_gain;
        logic [1:0]        rx_sel;
        logic [1:0]        ext_gc;
        logic [1:0]        filt_force;
        logic [TXG_W-1:0]  tx_code;
        logic [2:0]        gpo;
        logic [1:0]        loop_mode;
        logic              vdac_en;
        logic              hc2_en;
        logic              osr2;
        logic              vco_filt;
        logic [TUNE_W-1:0] hc_tune;
        logic [TUNE_W-1:0] sc_tune;
        logic [DAC_W-1:0]  vdac_val;
        logic [PWR_W-1:0]  pwr_en;
    } cfg_regs_t;

    localparam cfg_regs_t CFG_DEFAULT = '{
        rx_gain:    '0,
        rx_sel:     2'b11,
        ext_gc:     '0,
        filt_force: '0,
        tx_code:    '0,
        gpo:        '0,
        loop_mode:  '0,
        vdac_en:    1'b0,
        hc2_en:     1'b0,
        osr2:       1'b0,
        vco_filt:   1'b0,
        hc_tune:    '0,
        sc_tune:    '0,
        vdac_val:   '0,
        pwr_en:     '1
    };
endpackage

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
    import cfg_pkg::*;
#(
    parameter int STOP_N = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    output logic             commit,
    output logic [ID_W-1:0]  frame_id,
    output logic [PAY_W-1:0] payload
);
    localparam int BODY_W = FRAME_W - 1;
    localparam int BCNT_W = $clog2(BODY_W + 1);
    localparam int SCNT_W = $clog2(STOP_N + 1);

    rx_state_t         state_q, state_d;
    logic [BODY_W-1:0] body_q;
    logic [BCNT_W-1:0] bcnt_q;
    logic [SCNT_W-1:0] scnt_q;
    logic              body_last;
    logic              stop_last;

    assign body_last = (bcnt_q == BCNT_W'(BODY_W - 1));
    assign stop_last = (scnt_q == SCNT_W'(STOP_N - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!ser_in) state_d = ST_DATA;
            ST_DATA: if (body_last) state_d = ST_STOP;
            ST_STOP: begin
                if (!ser_in)        state_d = ST_DATA;
                else if (stop_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift register and counters
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            body_q <= '0;
            bcnt_q <= '0;
            scnt_q <= '0;
        end else begin
            if (state_q == ST_DATA) begin
                body_q <= {body_q[BODY_W-2:0], ser_in};
                bcnt_q <= body_last ? '0 : bcnt_q + 1'b1;
            end else begin
                bcnt_q <= '0;
            end
            if (state_q == ST_STOP && ser_in && !stop_last) scnt_q <= scnt_q + 1'b1;
            else                                            scnt_q <= '0;
        end
    end

    assign commit   = (state_q == ST_STOP) && ser_in && stop_last;
    assign frame_id = body_q[ID_W-1:0];
    assign payload  = body_q[BODY_W-1:ID_W];
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [ID_W-1:0]  frame_id,
    input  logic [PAY_W-1:0] payload,
    output cfg_regs_t        regs_q
);
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= CFG_DEFAULT;
        end else if (commit) begin
            unique case (reg_id_t'(frame_id))
                ID_RX: begin
                    regs_q.rx_gain    <= payload[4:0];
                    regs_q.rx_sel     <= payload[6:5];
                    regs_q.ext_gc     <= payload[8:7];
                    regs_q.filt_force <= payload[10:9];
                end
                ID_TX: begin
                    regs_q.tx_code <= payload[3:0];
                    regs_q.gpo     <= payload[11:9];
                end
                ID_MODE: begin
                    regs_q.loop_mode <= payload[1:0];
                    regs_q.vdac_en   <= payload[2];
                    regs_q.hc2_en    <= payload[3];
                    regs_q.osr2      <= payload[4];
                    regs_q.vco_filt  <= payload[5];
                end
                ID_TUNE: begin
                    regs_q.hc_tune <= payload[2:0];
                    regs_q.sc_tune <= payload[5:3];
                end
                ID_VDAC:  regs_q.vdac_val <= payload[7:0];
                ID_PWR:   regs_q.pwr_en   <= payload[7:0];
                ID_NONE:  begin end
                ID_SPARE: begin end
            endcase
        end
    end
endmodule

// File: rtl/cfg_pdn_sync.sv
module cfg_pdn_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level
);
    logic [SYNC_N-1:0] sync_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_N-2:0], pin};
    end

    assign level = sync_q[SYNC_N-1];
endmodule

// File: rtl/cfg_serial_ctl.sv
module cfg_serial_ctl
    import cfg_pkg::*;
#(
    parameter int STOP_N = 16,
    parameter int SYNC_N = 2
) (
    input  logic              word_clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              pdn_pin,
    output logic [RXG_W-1:0]  rx_gain,
    output logic [1:0]        rx_in_sel,
    output logic [1:0]        ext_gain_ctl,
    output logic [1:0]        filt_force,
    output logic [TXG_W-1:0]  tx_gain,
    output logic [2:0]        gpo,
    output logic [1:0]        loop_mode,
    output logic              vco_dac_en,
    output logic              hc2_en,
    output logic              osr2_mode,
    output logic              vco_filt,
    output logic [TUNE_W-1:0] hc_tune,
    output logic [TUNE_W-1:0] sc_tune,
    output logic [DAC_W-1:0]  vco_dac_val,
    output logic [PWR_W-1:0]  pwr_en,
    output logic              pd_status
);
    logic             commit_w;
    logic [ID_W-1:0]  id_w;
    logic [PAY_W-1:0] pay_w;
    cfg_regs_t        regs_w;

    cfg_frame_rx #(.STOP_N(STOP_N)) frame_i (
        .clk      (word_clk),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .commit   (commit_w),
        .frame_id (id_w),
        .payload  (pay_w)
    );

    cfg_reg_bank bank_i (
        .clk      (word_clk),
        .rst_n    (rst_n),
        .commit   (commit_w),
        .frame_id (id_w),
        .payload  (pay_w),
        .regs_q   (regs_w)
    );

    cfg_pdn_sync #(.SYNC_N(SYNC_N)) pdn_i (
        .clk   (word_clk),
        .rst_n (rst_n),
        .pin   (pdn_pin),
        .level (pd_status)
    );

    assign rx_gain      = regs_w.rx_gain;
    assign rx_in_sel    = regs_w.rx_sel;
    assign ext_gain_ctl = regs_w.ext_gc;
    assign filt_force   = regs_w.filt_force;
    assign tx_gain      = pd_status ? {TXG_W{1'b1}} : regs_w.tx_code;
    assign gpo          = regs_w.gpo;
    assign loop_mode    = regs_w.loop_mode;
    assign vco_dac_en   = regs_w.vdac_en;
    assign hc2_en       = regs_w.hc2_en;
    assign osr2_mode    = regs_w.osr2;
    assign vco_filt     = regs_w.vco_filt;
    assign hc_tune      = regs_w.hc_tune;
    assign sc_tune      = regs_w.sc_tune;
    assign vco_dac_val  = regs_w.vdac_val;
    assign pwr_en       = regs_w.pwr_en;
endmodule

// File: rtl/cfg_serial_ctl_chk.sv
module cfg_serial_ctl_chk
    import cfg_pkg::*;
#(
    parameter int STOP_N = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     commit,
    input logic [ID_W-1:0]          frame_id,
    input logic                     pd_status,
    input logic [TXG_W-1:0]         tx_gain,
    input logic [$bits(cfg_regs_t)-1:0] regs
);
    localparam int MIN_GAP = FRAME_W + STOP_N;
    localparam int GAP_W   = $clog2(MIN_GAP + 1);

    logic [GAP_W-1:0] gap_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)                             gap_q <= '0;
        else if (commit)                        gap_q <= '0;
        else if (gap_q < GAP_W'(MIN_GAP - 1))   gap_q <= gap_q + 1'b1;
    end

    // R2
    hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !commit |=> $stable(regs));

    // R9
    spare_id_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (commit && (frame_id == 3'd0 || frame_id == 3'd7)) |=> $stable(regs));

    // R12
    pd_force_chk: assert property (@(negedge clk) disable iff (!rst_n)
        pd_status |-> (tx_gain == {TXG_W{1'b1}}));

    // R2
    frame_gap_chk: assert property (@(negedge clk) disable iff (!rst_n)
        commit |-> (gap_q >= GAP_W'(MIN_GAP - 1)));
endmodule

bind cfg_serial_ctl cfg_serial_ctl_chk #(.STOP_N(STOP_N)) chk_i (
    .clk       (word_clk),
    .rst_n     (rst_n),
    .commit    (commit_w),
    .frame_id  (id_w),
    .pd_status (pd_status),
    .tx_gain   (tx_gain),
    .regs      (regs_w)
);

// File: tb/cfg_serial_ctl_tb_top.sv
`timescale 1ns/1ps
module cfg_serial_ctl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b1;
    logic pdn_pin = 1'b0;

    logic [4:0] rx_gain;
    logic [1:0] rx_in_sel, ext_gain_ctl, filt_force, loop_mode;
    logic [3:0] tx_gain;
    logic [2:0] gpo, hc_tune, sc_tune;
    logic       vco_dac_en, hc2_en, osr2_mode, vco_filt, pd_status;
    logic [7:0] vco_dac_val, pwr_en;

    always #2 clk = ~clk;

    cfg_serial_ctl dut_i (
        .word_clk(clk), .rst_n(rst_n), .ser_in(ser_in), .pdn_pin(pdn_pin),
        .rx_gain(rx_gain), .rx_in_sel(rx_in_sel), .ext_gain_ctl(ext_gain_ctl),
        .filt_force(filt_force), .tx_gain(tx_gain), .gpo(gpo), .loop_mode(loop_mode),
        .vco_dac_en(vco_dac_en), .hc2_en(hc2_en), .osr2_mode(osr2_mode),
        .vco_filt(vco_filt), .hc_tune(hc_tune), .sc_tune(sc_tune),
        .vco_dac_val(vco_dac_val), .pwr_en(pwr_en), .pd_status(pd_status)
    );

    wire [46:0] act_vec = {rx_gain, rx_in_sel, ext_gain_ctl, filt_force, tx_gain, gpo,
                           loop_mode, vco_dac_en, hc2_en, osr2_mode, vco_filt,
                           hc_tune, sc_tune, vco_dac_val, pwr_en, pd_status};

    // reference model
    logic [4:0] m_rxg;
    logic [1:0] m_sel, m_ext, m_force, m_loop;
    logic [3:0] m_tx;
    logic [2:0] m_gpo, m_hc, m_sc;
    logic       m_vden, m_hc2, m_osr2, m_vfilt, m_pd;
    logic [7:0] m_dac, m_pwr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [46:0] exp_q[$];
    string       tag_q[$];

    task automatic model_reset();
        m_rxg = 0; m_sel = 2'b11; m_ext = 0; m_force = 0; m_tx = 0; m_gpo = 0;
        m_loop = 0; m_vden = 0; m_hc2 = 0; m_osr2 = 0; m_vfilt = 0;
        m_hc = 0; m_sc = 0; m_dac = 0; m_pwr = 8'hFF; m_pd = 0;
    endtask

    function automatic logic [46:0] model_vec();
        return {m_rxg, m_sel, m_ext, m_force, (m_pd ? 4'hF : m_tx), m_gpo,
                m_loop, m_vden, m_hc2, m_osr2, m_vfilt, m_hc, m_sc, m_dac, m_pwr, m_pd};
    endfunction

    task automatic model_apply(input logic [2:0] id, input logic [11:0] p);
        case (id)
            3'd1: begin m_rxg = p[4:0]; m_sel = p[6:5]; m_ext = p[8:7]; m_force = p[10:9]; end
            3'd2: begin m_tx = p[3:0]; m_gpo = p[11:9]; end
            3'd3: begin m_loop = p[1:0]; m_vden = p[2]; m_hc2 = p[3]; m_osr2 = p[4]; m_vfilt = p[5]; end
            3'd4: begin m_hc = p[2:0]; m_sc = p[5:3]; end
            3'd5: m_dac = p[7:0];
            3'd6: m_pwr = p[7:0];
            default: ;
        endcase
    endtask

    task automatic compare(input logic [46:0] e, input string t);
        n_chk++;
        if (act_vec !== e) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", t, act_vec, e);
        end
    endtask

    // monitor: compares queued expectations one unit after the rising edge
    always @(posedge clk) begin
        logic [46:0] e;
        string t;
        #1;
        while (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compare(e, t);
        end
    end

    task automatic expect_now(input string tag);
        @(posedge clk);
        exp_q.push_back(model_vec());
        tag_q.push_back(tag);
    endtask

    task automatic send_bit(input logic b);
        @(posedge clk);
        ser_in = b;
    endtask

    task automatic send_body(input logic [2:0] id, input logic [11:0] p, input string pre_tag);
        logic [15:0] f;
        f = {1'b0, p, id};
        @(posedge clk);
        if (pre_tag != "") begin
            exp_q.push_back(model_vec());
            tag_q.push_back(pre_tag);
        end
        ser_in = f[15];
        for (int i = 14; i >= 0; i--) send_bit(f[i]);
    endtask

    task automatic send_stops(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic frame(input logic [2:0] id, input logic [11:0] p, input string tag);
        send_body(id, p, "");
        send_stops(16);
        model_apply(id, p);
        expect_now(tag);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        expect_now("R10 reset defaults");

        frame(3'd1, {1'b0, 2'b01, 2'b10, 2'b00, 5'd31}, "R1 R4 receive register, gain 31");
        frame(3'd2, {3'b101, 5'b0, 4'd9}, "R5 transmit code 9 and gpo");
        frame(3'd3, {6'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b10}, "R6 mode register");
        frame(3'd4, {6'b0, 3'b011, 3'b100}, "R7 tuning -4 and +3");
        frame(3'd5, 12'h0A5, "R8 dac value A5");
        frame(3'd6, 12'h03C, "R8 power enables 3C");
        frame(3'd7, 12'hFFF, "R9 id 7 ignored");
        frame(3'd0, 12'h5A5, "R9 id 0 ignored");

        // interrupted frame: 15 stops, then a new start bit
        send_body(3'd2, 12'h002, "");
        send_stops(15);
        send_body(3'd1, {1'b0, 2'b00, 2'b01, 2'b11, 5'd17}, "R2 R3 no commit after 15 stops");
        send_stops(16);
        model_apply(3'd1, {1'b0, 2'b00, 2'b01, 2'b11, 5'd17});
        expect_now("R3 interrupted frame dropped, next frame taken");

        // power-down
        @(posedge clk);
        pdn_pin = 1'b1;
        m_pd = 1'b1;
        @(posedge clk);
        expect_now("R11 R12 power-down status and forced tx gain");
        frame(3'd2, {3'b011, 5'b0, 4'd3}, "R12 frame accepted during power-down");
        @(posedge clk);
        pdn_pin = 1'b0;
        m_pd = 1'b0;
        @(posedge clk);
        expect_now("R11 R12 release restores stored tx code");

        // asynchronous reset between edges
        @(posedge clk);
        #1 rst_n = 1'b0;
        model_reset();
        #0.5 compare(model_vec(), "R10 asynchronous reset without clock edge");
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        expect_now("R10 defaults held after reset release");
        frame(3'd5, 12'h05A, "R8 frame after reset");

        repeat (3) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule